// File: doc/BRIEF.md
# Timer Channel: Capture, Compare and Edge PWM

This block is a single channel of a general-purpose timer. The counter sits outside it and supplies three things: the count value, a wrap pulse, and a mode bit that marks centre-aligned counting. The channel also takes one external pin. Software configures the channel through a small two-address register port. Address 0 is a status/control byte and address 1 holds the channel value, `CNT_W` bits wide.

In capture mode, the synchronised pin is watched for the selected edge. When that edge arrives, the current count is stored in the value register. In compare mode, the channel reacts when the count equals the stored value and, if configured, acts on the pin. In edge-aligned PWM mode, the pin goes to its active level on counter wrap and back to inactive on the value match. Every channel event sets a flag, and the flag drives an interrupt request when enabled. Clearing the flag takes two steps: software reads the control byte while the flag is set, and then writes a 0 to the flag bit. A new event arriving between those two steps cancels the clear.

When the edge/level field is 00, the pin is handed back to general-purpose I/O.

Top module: `tmr_chan`

## Requirements
- R1: After reset the control byte reads 0, the value register reads 0, `pin_o` is 0, `irq_o` is 0 and `gpio_rel_o` is 1.
- R2: `gpio_rel_o` is 1 exactly when the edge/level field (control bits 3:2) is 00, whatever the mode bits are.
- R3: Capture mode is selected by `cpwm_i`=0 with the mode bits (control bits 5:4) at 00. In this mode the edge/level field picks the capture edge: 01 is rising, 10 is falling, 11 is either. The flag sets at the third rising clock edge after `pin_i` changes. At that same edge, the value register takes `cnt_i`.
- R4: In capture mode with edge/level 00, pin transitions cause no event.
- R5: Compare mode is selected by `cpwm_i`=0 with the mode bits at 01. At each clock edge where `cnt_i` equals the value, the flag sets. At that edge the pin toggles for edge/level 01, goes to 0 for 10, goes to 1 for 11, and holds for 00 (software compare).
- R6: PWM mode is selected by `cpwm_i`=0 with mode bit B (bit 5) at 1. The active level is 1 when edge/level bit 3 is 1, and 0 otherwise. At an edge with `cnt_wrap_i`=1 the pin goes active. At an edge where the count matches the value, the pin goes inactive and the flag sets. A value of 0 holds the pin inactive. With a wrap pulse in the cycle the count shows 0, the pin is active for exactly `value` cycles per period.
- R7: `irq_o` is 1 exactly when the flag (bit 7) and the interrupt enable (bit 6) are both 1.
- R8: The flag clears only when a write to address 0 with bit 7 at 0 follows a read of address 0 that was made while the flag was set. A write without that read, or a write with bit 7 at 1, leaves the flag unchanged.
- R9: A channel event that falls between the arming read and the clearing write cancels the clear, so the flag stays 1.
- R10: While `cpwm_i` is 1, the channel takes no events and `pin_o` holds.
- R11: Reads of address 0 return {flag, enable, mode B, mode A, edge/level, 2'b00}, zero-extended. Reads of address 1 return the value. Writes to address 1 load the value. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_i | input | CNT_W | Free-running counter value |
| cnt_wrap_i | input | 1 | Counter wrap pulse, high in the cycle the count shows 0 |
| cpwm_i | input | 1 | Centre-aligned counting active |
| pin_i | input | 1 | Channel pin input (asynchronous) |
| bus_rd_i | input | 1 | Register read strobe |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 1 | 0 = control byte, 1 = value register |
| bus_wdata_i | input | CNT_W | Write data |
| bus_rdata_o | output | CNT_W | Read data |
| pin_o | output | 1 | Channel pin output level |
| gpio_rel_o | output | 1 | Pin released to general-purpose I/O |
| irq_o | output | 1 | Interrupt request |

## Verification
Some properties are checked by assertions on every cycle. These cover the rules that govern the flag: it falls only after an armed write, an event always leaves it set, writing a 1 does not clear it, and it stays frozen while centre-aligned counting is on. The assertions also check that a capture stores the count of the event cycle, that the release and interrupt outputs follow writes to the control byte, and that the pin holds when the channel has no match or no active mode. Other behaviour can only be shown by bench scenarios. These include edge selection across all three capture settings, the exact latency of the synchroniser, the four compare pin actions, the duty and polarity of PWM including a value of zero, and the race in which an event cancels a clear that has already been armed.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

    typedef enum logic [1:0] {
        MD_IDLE = 2'd0,
        MD_CAPT = 2'd1,
        MD_CMP  = 2'd2,
        MD_PWM  = 2'd3
    } chan_mode_e;

    typedef struct packed {
        logic       flag;
        logic       ie;
        logic       msb;
        logic       msa;
        logic [1:0] els;
        logic [1:0] rsv;
    } chan_ctrl_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } pin_edge_t;

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_VAL  = 1'b1;

    function automatic chan_mode_e mode_of(input logic cpwm, input logic msb, input logic msa);
        if (cpwm)     return MD_IDLE;
        else if (msb) return MD_PWM;
        else if (msa) return MD_CMP;
        else          return MD_CAPT;
    endfunction

    function automatic logic cmp_action(input logic [1:0] els, input logic cur);
        case (els)
            2'b01:   return ~cur;
            2'b10:   return 1'b0;
            2'b11:   return 1'b1;
            default: return cur;
        endcase
    endfunction

endpackage

// File: rtl/tmr_chan_insync.sv
module tmr_chan_insync
    import tmr_chan_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pin_i,
    output pin_edge_t edge_o
);
    localparam int LAST = STAGES;

    logic sh [LAST+1];

    for (genvar i = 0; i <= LAST; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) sh[0] <= 1'b0;
                else     sh[0] <= pin_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) sh[i] <= 1'b0;
                else     sh[i] <= sh[i-1];
            end
        end
    end

    always_comb begin
        edge_o.rise = sh[LAST-1] & ~sh[LAST];
        edge_o.fall = ~sh[LAST-1] & sh[LAST];
    end

    // R3
    rise_after_pin_high_chk: assert property (@(posedge clk) disable iff (rst)
        edge_o.rise |-> $past(pin_i, STAGES));

    // R3
    fall_after_pin_low_chk: assert property (@(posedge clk) disable iff (rst)
        edge_o.fall |-> !$past(pin_i, STAGES));

endmodule

// File: rtl/tmr_chan_flag.sv
module tmr_chan_flag (
    input  logic clk,
    input  logic rst,
    input  logic evt_i,
    input  logic arm_rd_i,
    input  logic ctrl_wr_i,
    input  logic wr_flag_i,
    output logic flag_o
);
    logic armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_o <= 1'b0;
            armed  <= 1'b0;
        end else if (evt_i) begin
            flag_o <= 1'b1;
            armed  <= 1'b0;
        end else begin
            if (ctrl_wr_i && !wr_flag_i && armed)
                flag_o <= 1'b0;
            if (ctrl_wr_i)
                armed <= 1'b0;
            else if (arm_rd_i && flag_o)
                armed <= 1'b1;
        end
    end

    // R8
    flag_clear_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(flag_o) |-> $past(armed && ctrl_wr_i && !wr_flag_i));

    // R9
    evt_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        evt_i |=> flag_o);

    // R8
    one_write_noop_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr_i && wr_flag_i && flag_o) |=> flag_o);

endmodule

// File: rtl/tmr_chan_outdrv.sv
module tmr_chan_outdrv
    import tmr_chan_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  chan_mode_e mode_i,
    input  logic [1:0] els_i,
    input  logic       match_i,
    input  logic       wrap_i,
    input  logic       val_zero_i,
    output logic       pin_o
);
    logic act_lvl;
    assign act_lvl = els_i[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_o <= 1'b0;
        end else begin
            case (mode_i)
                MD_CMP: begin
                    if (match_i)
                        pin_o <= cmp_action(els_i, pin_o);
                end
                MD_PWM: begin
                    if (els_i != 2'b00) begin
                        if (val_zero_i)   pin_o <= ~act_lvl;
                        else if (wrap_i)  pin_o <= act_lvl;
                        else if (match_i) pin_o <= ~act_lvl;
                    end
                end
                default: pin_o <= pin_o;
            endcase
        end
    end

    // R5
    cmp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MD_CMP && !match_i) |=> $stable(pin_o));

    // R6
    pwm_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MD_PWM && els_i != 2'b00 && val_zero_i) |=> (pin_o == !$past(els_i[1])));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MD_IDLE || mode_i == MD_CAPT) |=> $stable(pin_o));

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_chan_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             cnt_wrap_i,
    input  logic             cpwm_i,
    input  logic             pin_i,
    input  logic             bus_rd_i,
    input  logic             bus_wr_i,
    input  logic             bus_addr_i,
    input  logic [CNT_W-1:0] bus_wdata_i,
    output logic [CNT_W-1:0] bus_rdata_o,
    output logic             pin_o,
    output logic             gpio_rel_o,
    output logic             irq_o
);
    localparam int CTRL_W = $bits(chan_ctrl_t);

    logic             ie_q, msb_q, msa_q;
    logic [1:0]       els_q;
    logic [CNT_W-1:0] val_q;
    logic             flag;
    chan_mode_e       mode;
    pin_edge_t        pedge;
    logic             match, cap_evt, cmp_evt, evt;
    logic             ctrl_wr, val_wr, ctrl_rd;
    chan_ctrl_t       ctrl_view;

    assign ctrl_wr = bus_wr_i && (bus_addr_i == ADDR_CTRL);
    assign val_wr  = bus_wr_i && (bus_addr_i == ADDR_VAL);
    assign ctrl_rd = bus_rd_i && (bus_addr_i == ADDR_CTRL);

    assign mode    = mode_of(cpwm_i, msb_q, msa_q);
    assign match   = (cnt_i == val_q);
    assign cap_evt = (mode == MD_CAPT) &&
                     ((els_q[0] && pedge.rise) || (els_q[1] && pedge.fall));
    assign cmp_evt = (mode == MD_CMP || mode == MD_PWM) && match;
    assign evt     = cap_evt || cmp_evt;

    always_ff @(posedge clk) begin
        if (rst) begin
            ie_q  <= 1'b0;
            msb_q <= 1'b0;
            msa_q <= 1'b0;
            els_q <= 2'b00;
        end else if (ctrl_wr) begin
            ie_q  <= bus_wdata_i[6];
            msb_q <= bus_wdata_i[5];
            msa_q <= bus_wdata_i[4];
            els_q <= bus_wdata_i[3:2];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          val_q <= '0;
        else if (cap_evt) val_q <= cnt_i;
        else if (val_wr)  val_q <= bus_wdata_i;
    end

    tmr_chan_insync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (pin_i),
        .edge_o (pedge)
    );

    tmr_chan_flag u_flag (
        .clk       (clk),
        .rst       (rst),
        .evt_i     (evt),
        .arm_rd_i  (ctrl_rd),
        .ctrl_wr_i (ctrl_wr),
        .wr_flag_i (bus_wdata_i[7]),
        .flag_o    (flag)
    );

    tmr_chan_outdrv u_out (
        .clk        (clk),
        .rst        (rst),
        .mode_i     (mode),
        .els_i      (els_q),
        .match_i    (match),
        .wrap_i     (cnt_wrap_i),
        .val_zero_i (val_q == '0),
        .pin_o      (pin_o)
    );

    always_comb begin
        ctrl_view.flag = flag;
        ctrl_view.ie   = ie_q;
        ctrl_view.msb  = msb_q;
        ctrl_view.msa  = msa_q;
        ctrl_view.els  = els_q;
        ctrl_view.rsv  = 2'b00;
        if (bus_addr_i == ADDR_VAL) bus_rdata_o = val_q;
        else                        bus_rdata_o = CNT_W'(ctrl_view);
    end

    assign irq_o      = flag && ie_q;
    assign gpio_rel_o = (els_q == 2'b00);

    // R3
    capture_latch_chk: assert property (@(posedge clk) disable iff (rst)
        cap_evt |=> (val_q == $past(cnt_i)));

    // R2
    gpio_rel_follow_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> (gpio_rel_o == ($past(bus_wdata_i[3:2]) == 2'b00)));

    // R7
    irq_off_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !bus_wdata_i[6]) |=> !irq_o);

    // R10
    cpwm_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (cpwm_i && !ctrl_wr) |=> $stable(bus_rdata_o[CTRL_W-1]) || $past(bus_addr_i) != bus_addr_i);

endmodule

// File: tb/tmr_chan_bench.sv
module tmr_chan_bench;
    localparam int CLK_P = 10;
    localparam int CW    = 16;
    localparam int PER   = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [CW-1:0] cnt = '0;
    logic          wrap = 1'b0;
    logic          cpwm = 1'b0;
    logic          pin = 1'b0;
    logic          rd = 1'b0, wr = 1'b0, addr = 1'b0;
    logic [CW-1:0] wdata = '0;
    logic [CW-1:0] rdata;
    logic          pin_o, gpio_rel, irq;

    int  total = 0;
    int  bad = 0;
    int  cyc = 0;
    bit  done = 0;

    // behavioural reference state
    bit        m_ie, m_flag, m_arm, m_pin;
    bit [1:0]  m_ms, m_els;
    int        m_val;
    bit        hist[$];

    tmr_chan #(.CNT_W(CW), .SYNC_STAGES(2)) u_tmr_chan (
        .clk(clk), .rst(rst), .cnt_i(cnt), .cnt_wrap_i(wrap), .cpwm_i(cpwm),
        .pin_i(pin), .bus_rd_i(rd), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pin_o(pin_o),
        .gpio_rel_o(gpio_rel), .irq_o(irq)
    );

    always #(CLK_P/2) clk = ~clk;

    // free-running counter with wrap pulse in the cycle showing 0
    always @(negedge clk) begin
        if (rst) begin
            cnt  <= '0;
            wrap <= 1'b0;
        end else begin
            cnt  <= (cnt == PER-1) ? '0 : cnt + 1'b1;
            wrap <= (cnt == PER-1);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        int  md;
        bit  rise, fall, hit, ev, nf, na, np, wc, rc, act;
        if (rst) begin
            m_ie = 0; m_ms = 0; m_els = 0; m_val = 0;
            m_flag = 0; m_arm = 0; m_pin = 0;
            hist = '{0, 0, 0};
        end else begin
            md   = cpwm ? 0 : (m_ms[1] ? 3 : (m_ms[0] ? 2 : 1));
            rise = hist[1] && !hist[2];
            fall = !hist[1] && hist[2];
            hit  = (int'(cnt) == m_val);
            ev   = (md == 1 && ((m_els[0] && rise) || (m_els[1] && fall))) ||
                   (md >= 2 && hit);
            wc   = wr && !addr;
            rc   = rd && !addr;
            np   = m_pin;
            if (md == 2 && hit) begin
                if (m_els == 1) np = !m_pin;
                else if (m_els == 2) np = 0;
                else if (m_els == 3) np = 1;
            end
            if (md == 3 && m_els != 0) begin
                act = m_els[1];
                if (m_val == 0) np = !act;
                else if (wrap) np = act;
                else if (hit) np = !act;
            end
            nf = m_flag; na = m_arm;
            if (ev) begin nf = 1; na = 0; end
            else begin
                if (wc && !wdata[7] && m_arm) nf = 0;
                if (wc) na = 0; else if (rc && m_flag) na = 1;
            end
            if (md == 1 && ev) m_val = int'(cnt);
            else if (wr && addr) m_val = int'(wdata);
            if (wc) begin m_ie = wdata[6]; m_ms = wdata[5:4]; m_els = wdata[3:2]; end
            m_flag = nf; m_arm = na; m_pin = np;
            hist.push_front(pin);
            void'(hist.pop_back());
        end
    end

    // cycle-by-cycle comparison against the reference
    always @(negedge clk) begin
        int exp_rd;
        if (!rst && !done) begin
            chk((m_ms[1] && !cpwm) ? "R6 pin" : "R5 pin", pin_o, m_pin);
            chk("R7 irq", irq, m_flag && m_ie);
            chk("R2 gpio_rel", gpio_rel, m_els == 0);
            exp_rd = addr ? m_val : ({m_flag, m_ie, m_ms, m_els, 2'b00});
            chk("R11 rdata", rdata, exp_rd);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            bad++; total++;
            $display("FAIL watchdog all-reqs act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [CW-1:0] ctl(input bit ie, input bit [1:0] ms, input bit [1:0] els,
                                          input bit fl);
        return CW'({fl, ie, ms, els, 2'b00});
    endfunction

    task automatic bus_wr(input logic a, input logic [CW-1:0] d);
        @(negedge clk); #1;
        wr = 1; addr = a; wdata = d;
        @(negedge clk); #1;
        wr = 0; addr = 0;
    endtask

    task automatic bus_rd(input logic a, output logic [CW-1:0] d);
        @(negedge clk); #1;
        rd = 1; addr = a;
        #1 d = rdata;
        @(negedge clk); #1;
        rd = 0; addr = 0;
    endtask

    task automatic pin_to(input bit v, output int exp_cap);
        @(negedge clk); #1;
        pin = v;
        exp_cap = (int'(cnt) + 2) % PER;
        repeat (4) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [CW-1:0] d;
        int ec, hi, p0;
        repeat (3) @(negedge clk);
        #1 rst = 0;
        #1;
        // R1 reset state
        chk("R1 ctrl", rdata, 0);
        chk("R1 irq", irq, 0);
        chk("R1 pin", pin_o, 0);
        chk("R1 gpio_rel", gpio_rel, 1);
        bus_rd(1, d);
        chk("R1 value", d, 0);

        // R2 release follows edge/level only
        bus_wr(0, ctl(0, 2'b01, 2'b00, 0));
        chk("R2 released mode01", gpio_rel, 1);
        bus_wr(0, ctl(0, 2'b10, 2'b10, 0));
        chk("R2 claimed", gpio_rel, 0);

        // R11 map: reserved bits read 0, flag not settable by write
        bus_wr(0, CW'(16'h00FF) & ~CW'(16'h0030));
        bus_rd(0, d);
        chk("R11 ctrl readback", d, 16'h004C);
        chk("R8 write1 no set", d[7], 0);
        bus_wr(1, 16'h1234);
        bus_rd(1, d);
        chk("R11 value rw", d, 16'h1234);

        // R3 rising capture with interrupt
        bus_wr(0, ctl(1, 2'b00, 2'b01, 0));
        pin_to(1, ec);
        bus_rd(1, d);
        chk("R3 rise captured", d, ec);
        chk("R7 irq on", irq, 1);
        // R8 write 0 without arming read
        bus_wr(0, ctl(1, 2'b00, 2'b01, 0));
        chk("R8 no arm no clear", irq, 1);
        // R8 write 1 after arming read
        bus_rd(0, d);
        bus_wr(0, ctl(1, 2'b00, 2'b01, 1));
        chk("R8 write1 no clear", irq, 1);
        // R8 proper sequence
        bus_rd(0, d);
        bus_wr(0, ctl(1, 2'b00, 2'b01, 0));
        chk("R8 cleared", irq, 0);
        // R3 rising-only ignores falling
        pin_to(0, ec);
        chk("R3 fall ignored", irq, 0);
        // R3 falling only
        bus_wr(0, ctl(1, 2'b00, 2'b10, 0));
        pin_to(1, ec);
        chk("R3 rise ignored", irq, 0);
        pin_to(0, ec);
        bus_rd(1, d);
        chk("R3 fall captured", d, ec);
        bus_rd(0, d);
        bus_wr(0, ctl(1, 2'b00, 2'b11, 0));
        // R3 both edges
        pin_to(1, ec);
        bus_rd(1, d);
        chk("R3 both rise", d, ec);
        // R9 event between arming read and write
        bus_rd(0, d);
        pin_to(0, ec);
        bus_wr(0, ctl(1, 2'b00, 2'b11, 0));
        chk("R9 clear cancelled", irq, 1);
        bus_rd(1, d);
        chk("R3 both fall", d, ec);
        bus_rd(0, d);
        bus_wr(0, ctl(1, 2'b00, 2'b00, 0));
        chk("R9 later clear ok", irq, 0);
        // R4 edge/level 00 capture ignores pin
        pin_to(1, ec);
        pin_to(0, ec);
        chk("R4 no event", irq, 0);

        // R5 compare set / clear / toggle / software
        bus_wr(1, 16'd5);
        bus_wr(0, ctl(1, 2'b01, 2'b11, 0));
        idle(PER + 2);
        chk("R5 set on match", pin_o, 1);
        chk("R5 flag on match", irq, 1);
        bus_wr(0, ctl(1, 2'b01, 2'b10, 0));
        idle(PER + 2);
        chk("R5 clear on match", pin_o, 0);
        bus_wr(0, ctl(1, 2'b01, 2'b01, 0));
        idle(PER + 2);
        p0 = pin_o;
        idle(PER);
        chk("R5 toggle", pin_o, !p0);
        bus_wr(0, ctl(1, 2'b01, 2'b00, 0));
        p0 = pin_o;
        bus_rd(0, d);
        bus_wr(0, ctl(1, 2'b01, 2'b00, 0));
        idle(PER + 2);
        chk("R5 soft pin hold", pin_o, p0);
        chk("R5 soft flag", irq, 1);

        // R6 PWM high-true duty
        bus_wr(1, 16'd8);
        bus_wr(0, ctl(0, 2'b10, 2'b10, 0));
        idle(2 * PER);
        hi = 0;
        for (int i = 0; i < PER; i++) begin @(negedge clk); hi += pin_o; end
        chk("R6 high-true duty", hi, 8);
        // R6 low-true
        bus_wr(0, ctl(0, 2'b10, 2'b01, 0));
        idle(2 * PER);
        hi = 0;
        for (int i = 0; i < PER; i++) begin @(negedge clk); hi += !pin_o; end
        chk("R6 low-true duty", hi, 8);
        // R6 value 0
        bus_wr(1, 16'd0);
        bus_wr(0, ctl(0, 2'b10, 2'b10, 0));
        idle(PER);
        hi = 0;
        for (int i = 0; i < PER; i++) begin @(negedge clk); hi += pin_o; end
        chk("R6 zero duty", hi, 0);

        // R10 centre-aligned freezes the channel
        bus_rd(0, d);
        bus_wr(0, ctl(1, 2'b01, 2'b01, 0));
        @(negedge clk); #1 cpwm = 1;
        p0 = pin_o;
        idle(2 * PER);
        chk("R10 pin hold", pin_o, p0);
        chk("R10 no flag", irq, 0);
        @(negedge clk); #1 cpwm = 0;
        idle(4);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule